// File: doc/BRIEF.md
# Daisy-Chain Register Read Sequencer

This block is the host-side engine that reads one register out of every converter in a daisy chain that shares a single SPI select. One start request carries a bank number, a register address and the chain length. The block then runs four chip-select windows, one after another, each carrying one 24-bit word per device. The first window sets the register bank. The second sets the read-enable bit to its enabling value (0). The third sends the read command with the target address, which makes each device load its output shift register. The fourth clocks out filler so that every device's answer reaches the host.

Each answer holds the address the device echoes back and its 16-bit register data. Answers are stored by chain position. The block raises a mismatch flag for any position whose echoed address differs from the requested one, and ends the request with a one-cycle done pulse. The serial side runs in SPI mode 0, MSB first, with a parameterised clock divider.

Top module: `chain_reg_reader`

## Requirements
- R1: After reset `cs_n_o` is 1, `sclk_o` is 0, `busy_o` and `done_o` are 0, and every result output is 0.
- R2: A request produces exactly four chip-select low windows. Each window holds 24·N rising SCLK edges, where N = `len_i` + 1 (so `len_i` = 0 means one device).
- R3: The 24-bit word repeated N times in each window is as follows. Window 1 is {PAGE_REG, 8'h00, bank}. Window 2 is {RDEN_REG, 16'h0000}. Window 3 is {8'hFE, 8'h00, addr}. Window 4 is 24'hFFFFFF. Bits go out MSB first.
- R4: The serial side uses SPI mode 0. SCLK is low whenever CS is high. MOSI changes only on a falling SCLK edge or when CS falls, and MISO is sampled on the rising SCLK edge.
- R5: While CS is low, every SCLK high and low phase lasts exactly HALF_DIV system clocks.
- R6: Between consecutive windows of one request, CS stays high for at least 2 SCLK periods (4·HALF_DIV system clocks).
- R7: The k-th 24-bit word received in window 4 (k counted from 0) goes to position k. Bits [23:16] go to `echo_addr_o[k*8 +: 8]` and bits [15:0] go to `rd_data_o[k*16 +: 16]`. Positions k ≥ N read 0 after the request.
- R8: `mismatch_o[k]` is 1 exactly when the echoed address at position k < N differs from the requested address.
- R9: `done_o` is high for exactly one cycle once all results are valid. `busy_o` is high from the cycle after a start is accepted through the done cycle, and low in the cycle after it.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running request keeps its address and bank, and only one done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when not busy |
| bank_i | input | 8 | Register bank to select |
| addr_i | input | 8 | Register address to read |
| len_i | input | LEN_W | Chain length minus one |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| echo_addr_o | output | N_MAX·8 | Echoed address per chain position |
| rd_data_o | output | N_MAX·16 | Register data per chain position |
| mismatch_o | output | N_MAX | Echoed address differs from request |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | Serial data to the chain |
| miso_i | input | 1 | Serial data from the chain |

## Verification
The bench drives a behavioural chain of devices that decodes each window's word. A sequencer that skipped or garbled the bank or read-enable write would therefore read back wrong data or zeros at every position. Chains of length one and of full length check the word counter at both ends. A result stored at position k+1 instead of k would show up as rotated data. Mismatch faults are injected at chosen positions, so flags that were stuck, inverted or shifted would differ from the expected mask. A start pulse sent in the middle of a request tests R10: a design that re-latched its inputs would return data for the wrong address or pulse done twice. Per-window counts of SCLK edges, phase lengths and CS high gaps catch divider and framing errors.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  localparam int unsigned FRAME_W = 24;
  localparam logic [7:0] RD_CMD   = 8'hFE;

  typedef enum logic [1:0] {
    PASS_PAGE = 2'd0,
    PASS_RDEN = 2'd1,
    PASS_ADDR = 2'd2,
    PASS_READ = 2'd3
  } pass_e;

  function automatic logic [FRAME_W-1:0] pass_word(
    input pass_e      pass,
    input logic [7:0] page_reg,
    input logic [7:0] rden_reg,
    input logic [7:0] bank,
    input logic [7:0] addr
  );
    unique case (pass)
      PASS_PAGE: pass_word = {page_reg, 8'h00, bank};
      PASS_RDEN: pass_word = {rden_reg, 16'h0000};
      PASS_ADDR: pass_word = {RD_CMD, 8'h00, addr};
      default:   pass_word = {FRAME_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/chain_rd_engine.sv
module chain_rd_engine #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned GAP_SCLK = 2,
  parameter int unsigned LEN_W    = 3,
  parameter int unsigned FRAME_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic [LEN_W-1:0]   last_i,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic               mosi_o,
  output logic               rx_valid_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic [LEN_W-1:0]   rx_idx_o,
  output logic               pass_done_o
);
  localparam int unsigned CNT_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BIT_W      = $clog2(FRAME_W);
  localparam int unsigned GAP_HALVES = 2 * GAP_SCLK;
  localparam int unsigned GAP_W      = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  typedef enum logic [2:0] {E_IDLE, E_LOW, E_HIGH, E_TAIL, E_GAP} eng_e;

  eng_e               state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BIT_W-1:0]   bit_q;
  logic [LEN_W-1:0]   word_q;
  logic [FRAME_W-1:0] tx_q, rx_q;
  logic [GAP_W-1:0]   gap_q;
  logic               sclk_q, cs_n_q, rx_valid_q, done_q;
  logic [LEN_W-1:0]   rx_idx_q;
  logic               tick;

  assign tick = (cnt_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= E_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      word_q     <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      gap_q      <= '0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      rx_valid_q <= 1'b0;
      rx_idx_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      done_q     <= 1'b0;
      if (state_q == E_IDLE) cnt_q <= '0;
      else                   cnt_q <= tick ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        E_IDLE: if (go_i) begin
          cs_n_q  <= 1'b0;
          tx_q    <= word_i;
          bit_q   <= '0;
          word_q  <= '0;
          state_q <= E_LOW;
        end
        E_LOW: if (tick) begin
          sclk_q  <= 1'b1;
          rx_q    <= {rx_q[FRAME_W-2:0], miso_i};
          state_q <= E_HIGH;
        end
        E_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (bit_q == BIT_W'(FRAME_W - 1)) begin
            rx_valid_q <= 1'b1;
            rx_idx_q   <= word_q;
            bit_q      <= '0;
            if (word_q == last_i) begin
              state_q <= E_TAIL;
            end else begin
              word_q  <= word_q + 1'b1;
              tx_q    <= word_i;
              state_q <= E_LOW;
            end
          end else begin
            bit_q   <= bit_q + 1'b1;
            tx_q    <= {tx_q[FRAME_W-2:0], 1'b0};
            state_q <= E_LOW;
          end
        end
        E_TAIL: if (tick) begin
          cs_n_q  <= 1'b1;
          gap_q   <= '0;
          state_q <= E_GAP;
        end
        E_GAP: if (tick) begin
          if (gap_q == GAP_W'(GAP_HALVES - 1)) begin
            done_q  <= 1'b1;
            state_q <= E_IDLE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end

  assign sclk_o      = sclk_q;
  assign cs_n_o      = cs_n_q;
  assign mosi_o      = tx_q[FRAME_W-1];
  assign rx_valid_o  = rx_valid_q;
  assign rx_word_o   = rx_q;
  assign rx_idx_o    = rx_idx_q;
  assign pass_done_o = done_q;
endmodule

// File: rtl/chain_rd_ctrl.sv
module chain_rd_ctrl
  import chain_rd_pkg::*;
#(
  parameter int unsigned LEN_W    = 3,
  parameter logic [7:0]  PAGE_REG = 8'h04,
  parameter logic [7:0]  RDEN_REG = 8'h01
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         bank_i,
  input  logic [7:0]         addr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               pass_done_i,
  input  logic               rx_valid_i,
  output logic               go_o,
  output logic [FRAME_W-1:0] word_o,
  output logic [LEN_W-1:0]   last_o,
  output logic               clear_o,
  output logic               store_o,
  output logic [7:0]         req_addr_o,
  output logic               busy_o,
  output logic               done_o
);
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_DONE} seq_e;

  seq_e             state_q;
  pass_e            pass_q;
  logic [7:0]       bank_q, addr_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pass_q  <= PASS_PAGE;
      bank_q  <= '0;
      addr_q  <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          bank_q  <= bank_i;
          addr_q  <= addr_i;
          len_q   <= len_i;
          pass_q  <= PASS_PAGE;
          state_q <= S_LAUNCH;
        end
        S_LAUNCH: state_q <= S_WAIT;
        S_WAIT: if (pass_done_i) begin
          if (pass_q == PASS_READ) begin
            state_q <= S_DONE;
          end else begin
            pass_q  <= pass_e'(pass_q + 2'd1);
            state_q <= S_LAUNCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign go_o       = (state_q == S_LAUNCH);
  assign word_o     = pass_word(pass_q, PAGE_REG, RDEN_REG, bank_q, addr_q);
  assign last_o     = len_q;
  assign clear_o    = (state_q == S_IDLE) && start_i;
  assign store_o    = rx_valid_i && (pass_q == PASS_READ) && (state_q == S_WAIT);
  assign req_addr_o = addr_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
endmodule

// File: rtl/chain_rd_results.sv
module chain_rd_results #(
  parameter int unsigned N_MAX   = 8,
  parameter int unsigned LEN_W   = 3,
  parameter int unsigned FRAME_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                wr_i,
  input  logic [LEN_W-1:0]    idx_i,
  input  logic [FRAME_W-1:0]  word_i,
  input  logic [7:0]          req_addr_i,
  output logic [N_MAX*8-1:0]  echo_addr_o,
  output logic [N_MAX*16-1:0] rd_data_o,
  output logic [N_MAX-1:0]    mismatch_o
);
  for (genvar g = 0; g < N_MAX; g++) begin : g_slot
    logic [7:0]  echo_q;
    logic [15:0] data_q;
    logic        miss_q;
    logic        hit;

    assign hit = wr_i && (idx_i == LEN_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        echo_q <= '0;
        data_q <= '0;
        miss_q <= 1'b0;
      end else if (clear_i) begin
        echo_q <= '0;
        data_q <= '0;
        miss_q <= 1'b0;
      end else if (hit) begin
        echo_q <= word_i[23:16];
        data_q <= word_i[15:0];
        miss_q <= (word_i[23:16] != req_addr_i);
      end
    end

    assign echo_addr_o[g*8 +: 8]  = echo_q;
    assign rd_data_o[g*16 +: 16]  = data_q;
    assign mismatch_o[g]          = miss_q;
  end
endmodule

// File: rtl/chain_reg_reader.sv
module chain_reg_reader
  import chain_rd_pkg::*;
#(
  parameter int unsigned N_MAX    = 8,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned GAP_SCLK = 2,
  parameter logic [7:0]  PAGE_REG = 8'h04,
  parameter logic [7:0]  RDEN_REG = 8'h01,
  localparam int unsigned LEN_W   = (N_MAX > 1) ? $clog2(N_MAX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [7:0]          bank_i,
  input  logic [7:0]          addr_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [N_MAX*8-1:0]  echo_addr_o,
  output logic [N_MAX*16-1:0] rd_data_o,
  output logic [N_MAX-1:0]    mismatch_o,
  output logic                sclk_o,
  output logic                cs_n_o,
  output logic                mosi_o,
  input  logic                miso_i
);
  logic               go, pass_done, rx_valid, clear, store;
  logic [FRAME_W-1:0] word, rx_word;
  logic [LEN_W-1:0]   last, rx_idx;
  logic [7:0]         req_addr;

  chain_rd_ctrl #(
    .LEN_W(LEN_W), .PAGE_REG(PAGE_REG), .RDEN_REG(RDEN_REG)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .bank_i, .addr_i, .len_i,
    .pass_done_i(pass_done), .rx_valid_i(rx_valid),
    .go_o(go), .word_o(word), .last_o(last), .clear_o(clear),
    .store_o(store), .req_addr_o(req_addr), .busy_o, .done_o
  );

  chain_rd_engine #(
    .HALF_DIV(HALF_DIV), .GAP_SCLK(GAP_SCLK), .LEN_W(LEN_W), .FRAME_W(FRAME_W)
  ) u_engine (
    .clk_i, .rst_ni, .go_i(go), .word_i(word), .last_i(last), .miso_i,
    .sclk_o, .cs_n_o, .mosi_o,
    .rx_valid_o(rx_valid), .rx_word_o(rx_word), .rx_idx_o(rx_idx),
    .pass_done_o(pass_done)
  );

  chain_rd_results #(
    .N_MAX(N_MAX), .LEN_W(LEN_W), .FRAME_W(FRAME_W)
  ) u_results (
    .clk_i, .rst_ni, .clear_i(clear), .wr_i(store), .idx_i(rx_idx),
    .word_i(rx_word), .req_addr_i(req_addr),
    .echo_addr_o, .rd_data_o, .mismatch_o
  );
endmodule

// File: rtl/chain_rd_checker.sv
module chain_rd_checker #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned GAP_SCLK = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic cs_n_o,
  input logic mosi_o,
  input logic busy_o,
  input logic done_o
);
  logic        sclk_d, cs_d, chg, cs_fell;
  logic [15:0] run_q, hi_q;

  assign chg     = (sclk_o != sclk_d);
  assign cs_fell = cs_d && !cs_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      run_q  <= '0;
      hi_q   <= '1;
    end else begin
      sclk_d <= sclk_o;
      cs_d   <= cs_n_o;
      if (chg || cs_fell)    run_q <= 16'd1;
      else if (run_q != '1)  run_q <= run_q + 1'b1;
      if (!cs_n_o)           hi_q <= '0;
      else if (hi_q != '1)   hi_q <= hi_q + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);  // R4
  AST_MOSI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !$fell(cs_n_o) && !$stable(mosi_o)) |-> $fell(sclk_o));  // R4
  AST_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && chg) |-> (run_q == 16'(HALF_DIV)));  // R5
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fell |-> (hi_q >= 16'(4 * HALF_DIV * GAP_SCLK / 2)));  // R6
  AST_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o);  // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R9
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);  // R9
endmodule

bind chain_reg_reader chain_rd_checker #(.HALF_DIV(HALF_DIV), .GAP_SCLK(GAP_SCLK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
  .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/chain_reg_reader_test.sv
module chain_reg_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM   = 8;
  localparam int HD   = 2;
  localparam logic [7:0] PG = 8'h04;
  localparam logic [7:0] RE = 8'h01;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] bank_i = '0, addr_i = '0;
  logic [2:0] len_i = '0;
  logic busy_o, done_o, sclk_o, cs_n_o, mosi_o, miso_i;
  logic [NM*8-1:0]  echo_addr_o;
  logic [NM*16-1:0] rd_data_o;
  logic [NM-1:0]    mismatch_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_reg_reader #(.N_MAX(NM), .HALF_DIV(HD), .GAP_SCLK(2), .PAGE_REG(PG), .RDEN_REG(RE)) uut (
    .clk_i(clk), .rst_ni, .start_i, .bank_i, .addr_i, .len_i, .busy_o, .done_o,
    .echo_addr_o, .rd_data_o, .mismatch_o, .sclk_o, .cs_n_o, .mosi_o, .miso_i
  );

  // behavioural chain: host MOSI -> dev[n-1] -> ... -> dev[0] -> host MISO
  logic [23:0] dsh [NM];
  logic        dout [NM];
  logic [7:0]  dpage [NM];
  logic        drden [NM];
  logic        dfault [NM];
  int dev_n = 1;
  int rise_cnt = 0, pass_cnt = 0;
  int pass_rises [4];
  logic [23:0] pass_word [4];

  function automatic logic [15:0] exp_data(int k, logic [7:0] b, logic [7:0] a);
    return {b ^ 8'(k * 37), a ^ 8'(k + 90)};
  endfunction

  assign miso_i = dout[0];

  always @(posedge sclk_o) if (cs_n_o === 1'b0) begin
    rise_cnt++;
    for (int k = 0; k < NM; k++)
      if (k < dev_n) dsh[k] <= {dsh[k][22:0], (k == dev_n-1) ? mosi_o : dout[(k+1)%NM]};
  end

  always @(negedge sclk_o) if (cs_n_o === 1'b0)
    for (int k = 0; k < NM; k++) dout[k] <= dsh[k][23];

  always @(negedge cs_n_o) begin
    rise_cnt = 0;
    for (int k = 0; k < NM; k++) dout[k] <= dsh[k][23];
  end

  always @(posedge cs_n_o) if (rise_cnt > 0) begin
    if (pass_cnt < 4) begin
      pass_rises[pass_cnt] = rise_cnt;
      pass_word[pass_cnt]  = dsh[0];
    end
    pass_cnt++;
    for (int k = 0; k < NM; k++) if (k < dev_n) begin
      if (dsh[k][23:16] == PG) dpage[k] <= dsh[k][7:0];
      else if (dsh[k][23:16] == RE) drden[k] <= dsh[k][0];
      else if (dsh[k][23:8] == 16'hFE00)
        dsh[k] <= drden[k] ? 24'h0 :
                  {dsh[k][7:0] ^ {7'b0, dfault[k]}, exp_data(k, dpage[k], dsh[k][7:0])};
    end
  end

  // timing monitors sampled away from the active edge
  int hi_run = 0, min_gap = 1 << 30, sc_run = 0, sc_min = 1 << 30, sc_max = 0;
  int mode_bad = 0, done_cnt = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (done_o) done_cnt++;
    if (cs_n_o) begin
      if (busy_o) hi_run++;
      sc_run = 0;
    end else begin
      if (prev_cs) begin
        if (pass_cnt > 0 && hi_run < min_gap) min_gap = hi_run;
        hi_run = 0;
      end
      if (sclk_o != prev_sclk && sc_run > 0) begin
        if (sc_run < sc_min) sc_min = sc_run;
        if (sc_run > sc_max) sc_max = sc_run;
        sc_run = 1;
      end else sc_run++;
      if (!prev_cs && mosi_o != prev_mosi && !(prev_sclk && !sclk_o)) mode_bad++;
    end
    if (cs_n_o && sclk_o) mode_bad++;
    prev_cs = cs_n_o; prev_sclk = sclk_o; prev_mosi = mosi_o;
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_txn(int n, logic [7:0] bank, logic [7:0] addr, logic [7:0] fmask, bit inject);
    int cyc;
    dev_n = n;
    for (int k = 0; k < NM; k++) begin
      dpage[k] = ~bank; drden[k] = 1'b1; dfault[k] = fmask[k]; dsh[k] = 24'h0; dout[k] = 1'b0;
    end
    pass_cnt = 0; min_gap = 1 << 30; sc_min = 1 << 30; sc_max = 0; mode_bad = 0; done_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; bank_i = bank; addr_i = addr; len_i = 3'(n - 1);
    @(negedge clk);
    start_i = 1'b0; bank_i = ~bank; addr_i = ~addr;
    check(busy_o === 1'b1, "R9 busy after start", 64'(busy_o), 64'd1);
    if (inject) begin
      repeat (300) @(negedge clk);
      start_i = 1'b1; addr_i = addr ^ 8'h55; bank_i = bank ^ 8'h0F; len_i = 3'd0;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 20000) begin @(negedge clk); cyc++; end
    check(done_o === 1'b1, "R9 done seen", 64'(done_o), 64'd1);
    check(busy_o === 1'b1, "R9 busy in done cycle", 64'(busy_o), 64'd1);
    for (int k = 0; k < NM; k++) begin
      logic [7:0]  ee = (k < n) ? (addr ^ {7'b0, fmask[k]}) : 8'h00;
      logic [15:0] ed = (k < n) ? exp_data(k, bank, addr) : 16'h0;
      logic        em = (k < n) ? fmask[k] : 1'b0;
      check(echo_addr_o[k*8 +: 8] === ee, $sformatf("R7 echo pos %0d", k), 64'(echo_addr_o[k*8 +: 8]), 64'(ee));
      check(rd_data_o[k*16 +: 16] === ed, $sformatf("R7 data pos %0d", k), 64'(rd_data_o[k*16 +: 16]), 64'(ed));
      check(mismatch_o[k] === em, $sformatf("R8 mismatch pos %0d", k), 64'(mismatch_o[k]), 64'(em));
    end
    @(negedge clk);
    check(done_o === 1'b0, "R9 done one cycle", 64'(done_o), 64'd0);
    check(busy_o === 1'b0, "R9 busy released", 64'(busy_o), 64'd0);
    repeat (40) @(negedge clk);
    check(done_cnt == 1, "R10 single done", 64'(done_cnt), 64'd1);
    check(busy_o === 1'b0, "R10 no restart", 64'(busy_o), 64'd0);
    check(pass_cnt == 4, "R2 window count", 64'(pass_cnt), 64'd4);
    for (int p = 0; p < 4; p++)
      check(pass_rises[p] == 24 * n, $sformatf("R2 edges window %0d", p), 64'(pass_rises[p]), 64'(24 * n));
    check(pass_word[0] === {PG, 8'h00, bank}, "R3 page word", 64'(pass_word[0]), 64'({PG, 8'h00, bank}));
    check(pass_word[1] === {RE, 16'h0000}, "R3 read-enable word", 64'(pass_word[1]), 64'({RE, 16'h0}));
    check(pass_word[2] === {8'hFE, 8'h00, addr}, "R3 address word", 64'(pass_word[2]), 64'({8'hFE, 8'h00, addr}));
    check(pass_word[3] === 24'hFFFFFF, "R3 filler word", 64'(pass_word[3]), 64'hFFFFFF);
    check(mode_bad == 0, "R4 mode 0 edges", 64'(mode_bad), 64'd0);
    check(sc_min == HD && sc_max == HD, "R5 half period", 64'(sc_max), 64'(HD));
    check(min_gap >= 4 * HD, "R6 CS gap", 64'(min_gap), 64'(4 * HD));
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < NM; k++) begin dsh[k] = '0; dout[k] = 1'b0; end
    repeat (3) @(negedge clk);
    check(cs_n_o === 1'b1 && sclk_o === 1'b0, "R1 serial idle", {62'b0, cs_n_o, sclk_o}, 64'd2);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags idle", {62'b0, busy_o, done_o}, 64'd0);
    check(echo_addr_o === '0 && rd_data_o[63:0] === '0 && mismatch_o === '0, "R1 results zero",
          64'(echo_addr_o), 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    run_txn(1, 8'h02, 8'h3C, 8'h00, 1'b0);
    run_txn(8, 8'h01, 8'hA5, 8'h00, 1'b0);
    run_txn(8, 8'hFF, 8'hFF, 8'hFF, 1'b0);
    run_txn(3, 8'h00, 8'h00, 8'h05, 1'b0);
    run_txn(5, 8'h02, 8'h7E, 8'h10, 1'b1);
    run_txn(2, 8'h01, 8'hFE, 8'h02, 1'b0);
    for (int i = 0; i < 10; i++) begin
      int n = 1 + int'($urandom % NM);
      logic [7:0] fm = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      run_txn(n, 8'($urandom), 8'($urandom), fm, 1'b0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule